// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits in front of one bank of a NOR-style flash and interprets the write cycles a host places on it. It watches each write strobe together with its address and data. It recognises the multi-cycle command sequences that start a word program, a sector erase or a whole-chip erase. When a sequence completes, it raises a single-cycle operation pulse along with the target address and data. It then holds a busy flag for a fixed number of cycles, standing in for the embedded program or erase algorithm. A read of `status` while busy gives 00h. Once the operation is over it gives FFh.

A shortcut mode drops the leading unlock pair from every sequence. The host enters it with a three-cycle command or by raising `acc_en`. It stays in force until the host writes the dedicated two-cycle exit. While in the shortcut mode, every write that does not belong to one of its four accepted sequences is dropped. Only the low eight data bits and the low eleven address bits take part in command matching.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset there is no operation pulse, `busy` and `bypass` are 0 and `status` reads FFh.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h and then any data at any address produce one cycle of `op_prog` after the fourth write. `op_addr` and `op_data` carry that fourth write.
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h produce one cycle of `op_chip_erase`.
- R4: The first five writes of R3 followed by 30h at any address produce one cycle of `op_sec_erase`, with `op_addr` equal to that address.
- R5: AAh@555h, 55h@2AAh, 20h@555h sets `bypass` from the cycle after the third write.
- R6: In bypass, A0h at any address followed by a data write produces `op_prog` with that address and data.
- R7: In bypass, 80h at any address, AAh@555h, 55h@2AAh and then 10h@555h gives `op_chip_erase`. If the fourth write is instead 30h at any address, the result is `op_sec_erase` at that address.
- R8: In bypass, any write outside the accepted sequences, including F0h and the three-cycle enter command, leaves `bypass` at 1 and issues nothing.
- R9: In bypass, 90h followed by 00h clears `bypass`. 90h followed by any other data leaves `bypass` at 1.
- R10: While `acc_en` is 1 and `bypass` is 0, `bypass` is 1 on the next cycle and the write on that edge is dropped. A two-cycle bypass program is then accepted.
- R11: In normal mode, a write that breaks a sequence returns the decoder to idle with no pulse. This includes F0h in the data cycle of a program.
- R12: `busy` is 1 for exactly BUSY_CYCLES cycles, starting the cycle after an operation pulse is issued. Writes taken while `busy` is 1 are ignored.
- R13: `status` is 00h while `busy` is 1 and FFh otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one write per cycle it is high |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; low byte is the command code |
| acc_en | input | 1 | Forces the shortcut (bypass) mode while high |
| op_prog | output | 1 | One-cycle program pulse |
| op_sec_erase | output | 1 | One-cycle sector erase pulse |
| op_chip_erase | output | 1 | One-cycle chip erase pulse |
| op_addr | output | AW | Address of the last issued operation |
| op_data | output | DW | Data of the last issued program |
| busy | output | 1 | Modelled algorithm in progress |
| bypass | output | 1 | Shortcut mode active |
| status | output | 8 | Polling value: 00h while busy, FFh when done |

## Verification
Every registered result is due on the cycle after the edge that takes the deciding write. This covers the operation pulses, `op_addr`, `op_data`, `busy` and `bypass`. `status` follows `busy` within that same cycle. The bench drives inputs and compares all outputs on the falling edge. Its behavioural model updates on the rising edge, so each comparison sees exactly one edge of latency. The model matches a queue of taken writes against sequence templates, which is independent of the state encoding.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter int BUSY_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          acc_en,
  output logic          op_prog,
  output logic          op_sec_erase,
  output logic          op_chip_erase,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          busy,
  output logic          bypass,
  output logic [7:0]    status
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [3:0] {
    RD, N_U1, N_U2, N_PS, N_ES, N_EU1, N_EU2,
    B_IDLE, B_PS, B_ES, B_EU1, B_EU2, B_RST
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt;
  logic iss_p, iss_s, iss_c;

  wire [7:0] cmd  = wr_data[7:0];
  wire       a555 = wr_addr[10:0] == 11'h555;
  wire       a2aa = wr_addr[10:0] == 11'h2AA;
  wire       take = wr_en && !busy;

  assign busy   = cnt != '0;
  assign bypass = st >= B_IDLE;
  assign status = busy ? 8'h00 : 8'hFF;

  always_comb begin
    nxt = st;
    iss_p = 1'b0;
    iss_s = 1'b0;
    iss_c = 1'b0;
    if (acc_en && !bypass) nxt = B_IDLE;
    else if (take) begin
      case (st)
        RD:     nxt = (a555 && cmd == 8'hAA) ? N_U1 : RD;
        N_U1:   nxt = (a2aa && cmd == 8'h55) ? N_U2 : RD;
        N_U2:   if (a555 && cmd == 8'hA0) nxt = N_PS;
                else if (a555 && cmd == 8'h80) nxt = N_ES;
                else if (a555 && cmd == 8'h20) nxt = B_IDLE;
                else nxt = RD;
        N_PS:   begin nxt = RD; iss_p = cmd != 8'hF0; end
        N_ES:   nxt = (a555 && cmd == 8'hAA) ? N_EU1 : RD;
        N_EU1:  nxt = (a2aa && cmd == 8'h55) ? N_EU2 : RD;
        N_EU2:  begin
                  nxt = RD;
                  iss_c = a555 && cmd == 8'h10;
                  iss_s = cmd == 8'h30;
                end
        B_IDLE: if (cmd == 8'hA0) nxt = B_PS;
                else if (cmd == 8'h80) nxt = B_ES;
                else if (cmd == 8'h90) nxt = B_RST;
        B_PS:   begin nxt = B_IDLE; iss_p = 1'b1; end
        B_ES:   nxt = (a555 && cmd == 8'hAA) ? B_EU1 : B_IDLE;
        B_EU1:  nxt = (a2aa && cmd == 8'h55) ? B_EU2 : B_IDLE;
        B_EU2:  begin
                  nxt = B_IDLE;
                  iss_c = a555 && cmd == 8'h10;
                  iss_s = cmd == 8'h30;
                end
        B_RST:  nxt = (cmd == 8'h00) ? RD : B_IDLE;
        default: nxt = RD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= RD;
      cnt <= '0;
      op_prog <= 1'b0;
      op_sec_erase <= 1'b0;
      op_chip_erase <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      st <= nxt;
      op_prog <= iss_p;
      op_sec_erase <= iss_s;
      op_chip_erase <= iss_c;
      if (iss_p || iss_s || iss_c) begin
        op_addr <= wr_addr;
        cnt <= CW'(BUSY_CYCLES);
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
      if (iss_p) op_data <= wr_data;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder_sva.sv
module flash_cmd_decoder_sva #(
  parameter int BUSY_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_en,
  input logic       op_prog,
  input logic       op_sec_erase,
  input logic       op_chip_erase,
  input logic       busy,
  input logic       bypass,
  input logic [7:0] status
);
  int busy_run;
  wire op_any = op_prog || op_sec_erase || op_chip_erase;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_run <= 0;
    else busy_run <= busy ? busy_run + 1 : 0;
  end

  assert_one_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_prog, op_sec_erase, op_chip_erase}));

  assert_busy_with_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
    op_any |-> busy);

  assert_no_op_when_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !op_any);

  assert_busy_bounded_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= BUSY_CYCLES);

  assert_status_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> status == 8'hFF);

  assert_status_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status != 8'hFF);

  assert_acc_forces_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !bypass) |=> bypass);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_sva #(.BUSY_CYCLES(BUSY_CYCLES)) chk_i (.*);

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int BUSY = 16;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, acc_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic op_prog, op_sec_erase, op_chip_erase, busy, bypass;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic [7:0] status;

  always #5 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .DW(DW), .BUSY_CYCLES(BUSY)) dut_i (.*);

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural model
  bit e_prog, e_sec, e_chip, e_byp;
  int e_addr, e_data, e_cnt;
  int qa[$], qd[$];

  function automatic int seq_state(input int ta[6], input int td[6], input int len);
    if (qa.size() > len) return 0;
    foreach (qa[i]) begin
      if (ta[i] >= 0 && (qa[i] & 'h7FF) != ta[i]) return 0;
      if (td[i] >= 0 && (qd[i] & 'hFF) != td[i]) return 0;
    end
    return (qa.size() == len) ? 2 : 1;
  endfunction

  always @(posedge clk) begin
    bit was_busy, issued, keep;
    int a, d;
    was_busy = e_cnt != 0;
    issued = 0;
    if (!rst_n) begin
      e_prog = 0; e_sec = 0; e_chip = 0; e_byp = 0;
      e_addr = 0; e_data = 0; e_cnt = 0;
      qa.delete(); qd.delete();
    end else begin
      e_prog = 0; e_sec = 0; e_chip = 0;
      a = int'(wr_addr); d = int'(wr_data);
      if (acc_en && !e_byp) begin
        e_byp = 1; qa.delete(); qd.delete();
      end else if (wr_en && !was_busy) begin
        qa.push_back(a); qd.push_back(d);
        keep = 0;
        if (!e_byp) begin
          int sp, se, sc, ss;
          sp = seq_state('{'h555,'h2AA,'h555,-1,0,0}, '{'hAA,'h55,'hA0,-1,0,0}, 4);
          se = seq_state('{'h555,'h2AA,'h555,0,0,0}, '{'hAA,'h55,'h20,0,0,0}, 3);
          sc = seq_state('{'h555,'h2AA,'h555,'h555,'h2AA,'h555}, '{'hAA,'h55,'h80,'hAA,'h55,'h10}, 6);
          ss = seq_state('{'h555,'h2AA,'h555,'h555,'h2AA,-1}, '{'hAA,'h55,'h80,'hAA,'h55,'h30}, 6);
          if (sp == 2 && (d & 'hFF) != 'hF0) begin e_prog = 1; e_data = d; issued = 1; end
          else if (se == 2) e_byp = 1;
          else if (sc == 2) begin e_chip = 1; issued = 1; end
          else if (ss == 2) begin e_sec = 1; issued = 1; end
          else if ((sp == 1 || se == 1 || sc == 1 || ss == 1) && (d & 'hFF) != 'hF0) keep = 1;
        end else begin
          int bp, bc, bs, bx;
          bp = seq_state('{-1,-1,0,0,0,0}, '{'hA0,-1,0,0,0,0}, 2);
          bc = seq_state('{-1,'h555,'h2AA,'h555,0,0}, '{'h80,'hAA,'h55,'h10,0,0}, 4);
          bs = seq_state('{-1,'h555,'h2AA,-1,0,0}, '{'h80,'hAA,'h55,'h30,0,0}, 4);
          bx = seq_state('{-1,-1,0,0,0,0}, '{'h90,'h00,0,0,0,0}, 2);
          if (bp == 2) begin e_prog = 1; e_data = d; issued = 1; end
          else if (bc == 2) begin e_chip = 1; issued = 1; end
          else if (bs == 2) begin e_sec = 1; issued = 1; end
          else if (bx == 2) e_byp = 0;
          else if (bp == 1 || bc == 1 || bs == 1 || bx == 1) keep = 1;
        end
        if (issued) e_addr = a;
        if (!keep) begin qa.delete(); qd.delete(); end
      end
      if (issued) e_cnt = BUSY;
      else if (was_busy) e_cnt = e_cnt - 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit eb;
      int est;
      eb = e_cnt != 0;
      est = eb ? 'h00 : 'hFF;
      checks++;
      if (op_prog !== e_prog || op_sec_erase !== e_sec || op_chip_erase !== e_chip ||
          int'(op_addr) != e_addr || int'(op_data) != e_data || busy !== eb ||
          bypass !== e_byp || int'(status) != est) begin
        fails++;
        $display("FAIL %s t=%0t act p%0b s%0b c%0b a%0h d%0h busy%0b byp%0b st%0h exp p%0b s%0b c%0b a%0h d%0h busy%0b byp%0b st%0h",
          cur_req, $time, op_prog, op_sec_erase, op_chip_erase, op_addr, op_data, busy, bypass, status,
          e_prog, e_sec, e_chip, e_addr, e_data, eb, e_byp, est);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr('h555, 'hAA); wr('h2AA, 'h55);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cur_req = "R1"; idle(3); rst_n = 1; idle(2);
    cur_req = "R2"; unlock(); wr('h555, 'hA0); wr('h12345, 'hBEEF);
    cur_req = "R12"; unlock(); wr('h555, 'hA0); wr('h00100, 'h1111); idle(BUSY + 2);
    cur_req = "R13"; unlock(); wr('h555, 'hA0); wr('h00200, 'h2222); idle(BUSY + 2);
    cur_req = "R3"; unlock(); wr('h555, 'h80); unlock(); wr('h555, 'h10); idle(BUSY + 2);
    cur_req = "R4"; unlock(); wr('h555, 'h80); unlock(); wr('h1A000, 'h30); idle(BUSY + 2);
    cur_req = "R11"; unlock(); wr('h555, 'h77); wr('h2AA, 'h55); wr('h555, 'hA0); idle(2);
    wr('h555, 'hAA); wr('h2AA, 'hF0); idle(2);
    unlock(); wr('h555, 'hA0); wr('h00300, 'h00F0); idle(2);
    unlock(); wr('h555, 'h80); wr('h555, 'hAA); wr('h2AB, 'h55); idle(2);
    cur_req = "R5"; unlock(); wr('h555, 'h20); idle(2);
    cur_req = "R8"; wr('h555, 'hF0); unlock(); wr('h555, 'h20); wr('h555, 'hA5); idle(2);
    cur_req = "R6"; wr('h000, 'hA0); wr('h0ABCD, 'h5A5A); idle(BUSY + 2);
    cur_req = "R7"; wr('h000, 'h80); unlock(); wr('h555, 'h10); idle(BUSY + 2);
    wr('h000, 'h80); unlock(); wr('h0C000, 'h30); idle(BUSY + 2);
    wr('h000, 'h80); wr('h555, 'hAA); wr('h555, 'h55); idle(2);
    cur_req = "R9"; wr('h000, 'h90); wr('h000, 'h12); idle(2);
    wr('h000, 'h90); wr('h000, 'h00); idle(2);
    unlock(); wr('h555, 'hA0); wr('h00400, 'h4444); idle(BUSY + 2);
    cur_req = "R10";
    @(negedge clk); acc_en = 1; wr_en = 1; wr_addr = 'h555; wr_data = 'hAA;
    @(negedge clk); wr_en = 0;
    wr('h000, 'hA0); wr('h1FFFF, 'hC3C3); idle(BUSY + 2);
    acc_en = 0;
    wr('h000, 'h90); wr('h000, 'h00); idle(3);
    cur_req = "R2"; unlock(); wr('h555, 'hA0); wr('h00055, 'h7777); idle(BUSY + 2);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule